// File: doc/BRIEF.md
# Successive-Approximation Capacitor-Array Sequencer

This block is the digital controller of a successive-approximation converter whose DAC is a binary-weighted switched-capacitor array working by charge redistribution. A start request in the idle state runs three phases. In the sampling phase every capacitor bottom plate is tied to the analog input and the common node is grounded. In the hold phase the common-node ground is opened and every plate is switched to ground, which traps the sampled charge. In the search phase one bit is resolved per clock, most significant first.

In each search cycle the controller drives the plates of the current trial code to the reference and all other plates to ground. It then takes the external comparator's decision on the edge that ends the cycle. A decision of 1 means the held input is at or above the trial level. The array, the comparator and any calibration are outside the block. The number of sampling clocks and the resolution are parameters.

Top module: `sar_cdac_ctrl`

## Requirements
- R1: During and after reset, until a start is accepted, every plate select field is 2'b00 (ground), `cm_gnd_on` is 1, `busy` and `done` are 0 and `result` is 0.
- R2: A start in the idle state makes `busy` go high in the next cycle. For exactly SAMPLE_CLKS cycles, every plate field is then 2'b01 (analog input) with `cm_gnd_on` at 1.
- R3: The sampling phase is followed by exactly one hold cycle, with `cm_gnd_on` at 0 and every plate field at 2'b00. The converted value is the input as it stood at the end of sampling; later input changes have no effect.
- R4: The first search cycle presents the mid-scale trial: only the most significant plate (field RES_W-1, bits [2*RES_W-1:2*RES_W-2]) is 2'b10 (reference), and all others are 2'b00.
- R5: In every search cycle, plate field i is 2'b10 exactly where the trial code has a 1. A comparator value of 1 keeps the tested bit and 0 clears it, and the next lower bit is set as the new trial. For a held value of 0x5A with RES_W=8, the trials are 0x80, 0x40, 0x60, 0x50, 0x58, 0x5C, 0x5A, 0x5B.
- R6: The search lasts exactly RES_W cycles. `done` is high in the cycle after the LSB decision edge. Counting the edge that accepts the start as edge 1, `done` is seen after edge SAMPLE_CLKS+RES_W+2.
- R7: `result` takes the final code in the `done` cycle, equals the held input for every value including 0 and all ones, and keeps its value until the next conversion completes.
- R8: `done` is high for exactly one cycle. `busy` is high from the cycle after the start through the `done` cycle and low in the cycle after, when the switches are back in the idle setting of R1.
- R9: A start raised while `busy` is high, including in the `done` cycle, is ignored: the running conversion keeps its length and result, and no new conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; one bit is resolved per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, accepted only when idle |
| cmp_above | input | 1 | Comparator decision: 1 when the held input is at or above the trial level |
| plate_sw | output | 2*RES_W | Per-capacitor switch select, field i at [2i+1:2i]: 00 ground, 01 analog input, 10 reference |
| cm_gnd_on | output | 1 | Closes the common-node ground switch |
| result | output | RES_W | Last completed conversion code |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse in the cycle the result is updated |

## Verification
The bench puts a behavioural comparator across the plate outputs. The comparator latches the input on the last sampling edge and compares it with the code read from the reference-driven plates. Mid-range codes such as 0x5A have their full trial sequences matched bit by bit against the expected prefix-plus-probe pattern, which shows whether keep and clear decisions are applied to the right bit. The extreme codes 0x00 and 0xFF, with every decision 0 or every decision 1, and the alternating codes 0xAA and 0x55 separate errors in the final LSB handling from errors in the shift order. One run changes the input during the hold cycle, which shows whether the sample is taken at the end of sampling. Other runs raise start during the search and in the done cycle, to tell an ignored request from a restart.

// File: rtl/sar_cdac_pkg.sv
// Shared types for the capacitor-array successive-approximation sequencer.
// Assumes: a plate switch select is two bits wide, one field per capacitor.
package sar_cdac_pkg;

    // Bottom-plate switch choice for one capacitor
    typedef enum logic [1:0] {
        SW_GND  = 2'b00,
        SW_VIN  = 2'b01,
        SW_VREF = 2'b10
    } plate_sw_e;

    // Conversion phase held by the sequencer
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_HOLD,
        PH_SEARCH,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/sar_phase_seq.sv
// Phase sequencer: idle -> sample (SAMPLE_CLKS cycles) -> hold (1 cycle)
// -> search (RES_W cycles, MSB first) -> done (1 cycle) -> idle.
// Assumes: start is synchronous to clk; it is only looked at in idle.
module sar_phase_seq
    import sar_cdac_pkg::*;
#(
    parameter int RES_W       = 8,
    parameter int SAMPLE_CLKS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    output phase_e                     phase,
    output logic [$clog2(RES_W)-1:0]   bit_idx
);
    localparam int IDX_W = $clog2(RES_W);
    localparam int SMP_W = $clog2(SAMPLE_CLKS + 1);
    localparam int RUN_W = $clog2(RES_W + SAMPLE_CLKS + 2);

    logic [SMP_W-1:0] smp_left;

    // Phase transitions, sampling countdown and search bit pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            smp_left <= '0;
            bit_idx  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase    <= PH_SAMPLE;
                        smp_left <= SMP_W'(SAMPLE_CLKS - 1);
                    end
                end
                PH_SAMPLE: begin
                    if (smp_left == '0) phase <= PH_HOLD;
                    else                smp_left <= smp_left - 1'b1;
                end
                PH_HOLD: begin
                    phase   <= PH_SEARCH;
                    bit_idx <= IDX_W'(RES_W - 1);
                end
                PH_SEARCH: begin
                    if (bit_idx == '0) phase <= PH_DONE;
                    else               bit_idx <= bit_idx - 1'b1;
                end
                PH_DONE:  phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // Checker support: length of the current run of one phase
    logic [RUN_W-1:0] run_len;
    phase_e           phase_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase;
            run_len <= (phase == phase_q) ? run_len + 1'b1 : RUN_W'(1);
        end
    end

    // R2: sampling lasts exactly SAMPLE_CLKS cycles
    a_r2_sample_len: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SAMPLE && phase == PH_HOLD) |-> run_len == RUN_W'(SAMPLE_CLKS));
    // R6: search lasts exactly RES_W cycles
    a_r6_search_len: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SEARCH && phase == PH_DONE) |-> run_len == RUN_W'(RES_W));
    // R3: a single hold cycle always precedes the search
    a_r3_one_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |=> (phase == PH_SEARCH));
    // R9: a start outside idle never reopens sampling
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD || phase == PH_SEARCH || phase == PH_DONE) |=> (phase != PH_SAMPLE));
endmodule

// File: rtl/sar_code_reg.sv
// Trial-code and result register: loads mid-scale after hold, then per
// search cycle keeps or clears the probed bit and probes the next lower one.
// Assumes: cmp_above is settled by the edge that ends each search cycle.
module sar_code_reg
    import sar_cdac_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  phase_e                    phase,
    input  logic [$clog2(RES_W)-1:0]  bit_idx,
    input  logic                      cmp_above,
    output logic [RES_W-1:0]          trial,
    output logic [RES_W-1:0]          result
);
    localparam int              IDX_W = $clog2(RES_W);
    localparam logic [RES_W-1:0] MID  = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] trial_dec;
    logic [RES_W-1:0] trial_nxt;

    // Apply the decision to the probed bit and set the next probe
    always_comb begin
        trial_dec = trial;
        if (!cmp_above) trial_dec[bit_idx] = 1'b0;
        trial_nxt = trial_dec;
        if (bit_idx != '0) trial_nxt[IDX_W'(bit_idx - 1'b1)] = 1'b1;
    end

    // Trial code and final result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial  <= '0;
            result <= '0;
        end else begin
            case (phase)
                PH_HOLD:   trial <= MID;
                PH_SEARCH: begin
                    trial <= trial_nxt;
                    if (bit_idx == '0) result <= trial_dec;
                end
                PH_IDLE:   trial <= '0;
                default:   trial <= trial;
            endcase
        end
    end

    // R4: the search opens at mid-scale
    a_r4_midscale: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SEARCH && $past(phase) == PH_HOLD) |-> trial == MID);
    // R5: the probed bit takes the comparator decision
    a_r5_keep_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SEARCH && bit_idx != '0) |=> trial[$past(bit_idx)] == $past(cmp_above));
    // R7: the LSB of the result is the last decision
    a_r7_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SEARCH && bit_idx == '0) |=> result[0] == $past(cmp_above));
    // R7: result changes only on entry to the done cycle
    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_DONE) |-> $stable(result));
endmodule

// File: rtl/sar_plate_drv.sv
// Switch decoder: maps phase and trial code onto per-capacitor bottom-plate
// selects and the common-node ground switch.
// Assumes: phase and trial are registers, so outputs move only after edges.
module sar_plate_drv
    import sar_cdac_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  phase_e                 phase,
    input  logic [RES_W-1:0]       trial,
    output logic [2*RES_W-1:0]     plate_sw,
    output logic                   cm_gnd_on
);
    // Common node grounded whenever no charge is being held
    assign cm_gnd_on = (phase == PH_IDLE) || (phase == PH_SAMPLE) || (phase == PH_DONE);

    for (genvar i = 0; i < RES_W; i++) begin : g_plate
        plate_sw_e sel;
        // Select for capacitor i in the current phase
        always_comb begin
            case (phase)
                PH_SAMPLE: sel = SW_VIN;
                PH_SEARCH: sel = trial[i] ? SW_VREF : SW_GND;
                default:   sel = SW_GND;
            endcase
        end
        assign plate_sw[2*i +: 2] = sel;
    end
endmodule

// File: rtl/sar_cdac_ctrl.sv
// Top of the capacitor-array successive-approximation sequencer.
// Assumes: RES_W in 8..16, SAMPLE_CLKS >= 1, comparator external.
module sar_cdac_ctrl
    import sar_cdac_pkg::*;
#(
    parameter int RES_W       = 8,
    parameter int SAMPLE_CLKS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   cmp_above,
    output logic [2*RES_W-1:0]     plate_sw,
    output logic                   cm_gnd_on,
    output logic [RES_W-1:0]       result,
    output logic                   busy,
    output logic                   done
);
    localparam int IDX_W = $clog2(RES_W);

    if (RES_W < 8 || RES_W > 16 || SAMPLE_CLKS < 1) begin : g_bad_param
        $error("sar_cdac_ctrl: parameter out of range");
    end

    phase_e           phase;
    logic [IDX_W-1:0] bit_idx;
    logic [RES_W-1:0] trial;

    sar_phase_seq #(.RES_W(RES_W), .SAMPLE_CLKS(SAMPLE_CLKS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .phase   (phase),
        .bit_idx (bit_idx)
    );

    sar_code_reg #(.RES_W(RES_W)) u_code (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .bit_idx   (bit_idx),
        .cmp_above (cmp_above),
        .trial     (trial),
        .result    (result)
    );

    sar_plate_drv #(.RES_W(RES_W)) u_drv (
        .phase     (phase),
        .trial     (trial),
        .plate_sw  (plate_sw),
        .cm_gnd_on (cm_gnd_on)
    );

    // Status decoded from the registered phase
    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_DONE);

    // R1: when idle the array is grounded and the common node clamped
    a_r1_idle_safe: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cm_gnd_on && plate_sw == '0));
    // R3: releasing the common node happens with every plate grounded
    a_r3_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cm_gnd_on) |-> plate_sw == '0);
    // R8: done is a single-cycle pulse and ends the busy period
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R2: an idle start raises busy on the next cycle
    a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
endmodule

// File: tb/sim_sar_cdac_ctrl.sv
// Directed bench with a behavioural comparator across the plate outputs.
module sim_sar_cdac_ctrl;
    localparam int N = 8;
    localparam int S = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           cmp_above;
    logic [2*N-1:0] plate_sw;
    logic           cm_gnd_on;
    logic [N-1:0]   result;
    logic           busy;
    logic           done;

    always #2 clk = ~clk;

    sar_cdac_ctrl #(.RES_W(N), .SAMPLE_CLKS(S)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_above(cmp_above),
        .plate_sw(plate_sw), .cm_gnd_on(cm_gnd_on), .result(result),
        .busy(busy), .done(done)
    );

    // Comparator model: read the plates and hold the input sampled on them
    int           vin_live = 0;
    int           held = 0;
    logic [N-1:0] vref_code;
    logic         all_vin;
    logic         any_vin;
    always_comb begin
        all_vin = 1'b1;
        any_vin = 1'b0;
        for (int i = 0; i < N; i++) begin
            vref_code[i] = (plate_sw[2*i +: 2] == 2'b10);
            if (plate_sw[2*i +: 2] != 2'b01) all_vin = 1'b0;
            if (plate_sw[2*i +: 2] == 2'b01) any_vin = 1'b1;
        end
    end
    always @(posedge clk) if (all_vin) held <= vin_live;
    assign cmp_above = (held >= int'(vref_code));

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Results of the last conversion
    int           samp_n, hold_n, srch_n, lat, busy_gap;
    logic [N-1:0] trials [N];

    function automatic logic [N-1:0] exp_trial(input int v, input int k);
        int pre;
        pre = (v >> (N - k)) << (N - k);
        return N'(pre | (1 << (N - 1 - k)));
    endfunction

    // Run one conversion; optional start pulse and input change at given cycles
    task automatic convert(input int v, input int pulse_at, input int chg_at, input int vnew);
        samp_n = 0; hold_n = 0; srch_n = 0; lat = 0; busy_gap = 0;
        for (int k = 0; k < N; k++) trials[k] = '0;
        @(negedge clk);
        vin_live = v;
        start = 1'b1;
        @(posedge clk);
        for (int cnt = 1; cnt <= 60; cnt++) begin
            @(negedge clk);
            if (!busy) busy_gap++;
            if (all_vin && cm_gnd_on) samp_n++;
            else if (plate_sw == '0 && !cm_gnd_on) hold_n++;
            else if (!cm_gnd_on && !any_vin) begin
                if (srch_n < N) trials[srch_n] = vref_code;
                srch_n++;
            end
            if (done) begin
                lat = cnt;
                break;
            end
            start = (cnt == pulse_at);
            if (cnt == chg_at) vin_live = vnew;
        end
        start = 1'b0;
    endtask

    task automatic check_conv(input string tag, input int v);
        chk({tag, " R6 latency"}, lat == S + N + 2, lat, S + N + 2);
        chk({tag, " R2 sample cycles"}, samp_n == S, samp_n, S);
        chk({tag, " R3 hold cycles"}, hold_n == 1, hold_n, 1);
        chk({tag, " R6 search cycles"}, srch_n == N, srch_n, N);
        chk({tag, " R4 first trial"}, trials[0] == N'(1 << (N - 1)), int'(trials[0]), 1 << (N - 1));
        chk({tag, " R7 result"}, result == N'(v), int'(result), v);
        chk({tag, " R8 busy through done"}, busy == 1'b1 && busy_gap == 0, busy_gap, 0);
    endtask

    task automatic check_idle_after(input string tag, input int v);
        @(negedge clk);
        chk({tag, " R8 idle after done"}, !busy && !done && cm_gnd_on && plate_sw == '0,
            {busy, done, cm_gnd_on}, 3'b001);
        chk({tag, " R7 result kept"}, result == N'(v), int'(result), v);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        start = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", !busy && !done && cm_gnd_on && plate_sw == '0 && result == '0,
            {busy, done, cm_gnd_on}, 3'b001);
        start = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", !busy && cm_gnd_on && plate_sw == '0 && result == '0,
            int'(plate_sw), 0);
    endtask

    task automatic t_sequence();
        logic ok;
        convert(32'h5A, 0, 0, 0);
        check_conv("seq5A", 32'h5A);
        ok = 1'b1;
        for (int k = 0; k < N; k++) begin
            if (trials[k] != exp_trial(32'h5A, k)) begin
                ok = 1'b0;
                chk("R5 trial order 0x5A", 1'b0, int'(trials[k]), int'(exp_trial(32'h5A, k)));
            end
        end
        chk("R5 trial list 0x5A", ok && trials[7] == 8'h5B && trials[2] == 8'h60, int'(trials[7]), 8'h5B);
        check_idle_after("seq5A", 32'h5A);
    endtask

    task automatic t_patterns();
        int vals [4] = '{0, 255, 32'hAA, 32'h55};
        foreach (vals[j]) begin
            logic ok;
            convert(vals[j], 0, 0, 0);
            check_conv("pattern", vals[j]);
            ok = 1'b1;
            for (int k = 0; k < N; k++) if (trials[k] != exp_trial(vals[j], k)) ok = 1'b0;
            chk("R5 trial sequence", ok, int'(trials[N-1]), int'(exp_trial(vals[j], N - 1)));
            check_idle_after("pattern", vals[j]);
        end
    endtask

    task automatic t_hold();
        convert(32'h37, S + 1, S + 1, 32'hC8);
        chk("R3 input change after sampling ignored", result == 8'h37, int'(result), 32'h37);
        check_conv("hold", 32'h37);
        check_idle_after("hold", 32'h37);
    endtask

    task automatic t_busy_start();
        convert(32'h9C, S + 4, 0, 0);
        check_conv("R9 start in search", 32'h9C);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 start in done cycle ignored", !busy && cm_gnd_on && plate_sw == '0, busy, 0);
        @(negedge clk);
        chk("R9 no new conversion", !busy && result == 8'h9C, busy, 0);
    endtask

    task automatic t_back_to_back();
        convert(32'h01, 0, 0, 0);
        check_conv("b2b first", 32'h01);
        convert(32'hFE, 0, 0, 0);
        check_conv("R2 b2b second", 32'hFE);
        check_idle_after("b2b", 32'hFE);
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_patterns();
        t_hold();
        t_busy_start();
        t_back_to_back();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule